// File: doc/BRIEF.md
# Full-Bridge PWM Generator with Windowed Cycle-by-Cycle Current Limit

This block drives the four switches of a full-bridge converter. The switching period is split into two halves. In the first half the diagonal pair made of the A-leg high switch and the B-leg low switch conducts. In the second half the opposite diagonal conducts, made of the B-leg high switch and the A-leg low switch. The transformer primary therefore sees one polarity and then the other. At the start of each half a programmable dead-time holds every switch off before that half's pair turns on. The on-time is clamped so that a pair always turns off before its half-period ends.

A digitized current sample is compared every clock with a signed upper limit and a signed lower limit. When the sample leaves that window, all four gates drop in the same clock cycle and stay off for the rest of the period. The current is tested again only on the first tick of the next period. If it is back inside the window, switching resumes. If it is still outside, that whole period is blanked and the test repeats one period later. The current limit therefore never adds a switching edge in the middle of a period.

Period, on-time and dead-time are counted in clock ticks. They are captured only on the first tick of a period, so every period runs with one consistent set of values.

Top module: `bridge_pwm_top`

## Requirements
- R1: The current is outside the window when `cur_i > lim_hi_i` or `cur_i < lim_lo_i`, both compared as signed values. A sample equal to either limit is inside. While the block is enabled, `limit_o` is high in any cycle where the sample is outside.
- R2: Ticks 0 to half−1 of a period form the first half, where half = period/2 rounded down. In the first half only `gate_ah_o` and `gate_bl_o` may be high, and they are high together. The remaining ticks form the second half, where only `gate_bh_o` and `gate_al_o` may be high, and they are high together.
- R3: Counting ticks from the start of its half, a pair is driven on ticks dead to dead+on−1, using the effective on-time. On the first dead ticks of each half, no gate is high.
- R4: The effective on-time is the smaller of the requested on-time and half−dead. It is zero when dead ≥ half. A requested period below 4 is treated as 4.
- R5: While the sample is outside the window, no gate is high in that same cycle. After a trip, all gates stay low and `limit_o` stays high until the next period start, even if the sample returns inside the window.
- R6: `limit_o` clears only on a period start where the sample is inside the window. If the sample is outside on the period start, the whole period is blanked.
- R7: `gate_ah_o` and `gate_al_o` are never high together. `gate_bh_o` and `gate_bl_o` are never high together.
- R8: Period, on-time and dead-time inputs are captured only on a period's first tick. A change made in the middle of a period does not alter that period's length or gate pattern.
- R9: `cyc_start_o` is high for exactly one clock, on tick 0 of every period. When `en_i` rises, the first period starts one clock later.
- R10: After reset, or in any cycle where `en_i` is low, all gates and `limit_o` are low. After enable returns, the first pair driven is the `gate_ah_o`/`gate_bl_o` pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Enable switching |
| period_i | input | CNT_W | Period in ticks |
| ontime_i | input | CNT_W | Requested on-time per half in ticks |
| dead_i | input | CNT_W | Dead-time at the start of each half in ticks |
| lim_hi_i | input | CUR_W | Signed upper current limit |
| lim_lo_i | input | CUR_W | Signed lower current limit |
| cur_i | input | CUR_W | Signed current sample |
| gate_ah_o | output | 1 | A-leg high switch |
| gate_al_o | output | 1 | A-leg low switch |
| gate_bh_o | output | 1 | B-leg high switch |
| gate_bl_o | output | 1 | B-leg low switch |
| limit_o | output | 1 | Current limit active (gates blanked) |
| cyc_start_o | output | 1 | One-clock strobe on tick 0 of each period |

## Verification
The pulse pattern is exercised with an even period and an odd period, and with on-time requests that fit, that are clamped, and that are wiped out by a dead-time of half the period or more. Comparing these cases shows whether the half split, the dead-time offset and the clamp are each right. The current input is tried with four patterns: a single out-of-window tick in the middle of a period, a sample held below the lower limit across a period start, a sample exactly equal to a limit, and a sample held inside the window. These separate immediate blanking, blanking that holds to the boundary, a fully blanked period, and off-by-one errors in the comparison. A period change made in the middle of a period, and an enable drop in the middle of a period, show whether values are captured only at the boundary and whether a restart begins with the first pair.

// File: rtl/bridge_pwm_pkg.sv
// Package: shared types for the full-bridge PWM block.
// Assumes: nothing beyond IEEE 1800-2017.
package bridge_pwm_pkg;

    // Which diagonal pair is commanded on this tick.
    typedef enum logic [1:0] {
        PAIR_NONE = 2'd0,
        PAIR_POS  = 2'd1,   // A-leg high + B-leg low
        PAIR_NEG  = 2'd2    // B-leg high + A-leg low
    } pair_e;

    // Smallest period the timebase will run.
    localparam int unsigned MIN_PERIOD = 4;

endpackage

// File: rtl/bridge_timebase.sv
// Module: bridge_timebase
// Counts ticks of one PWM period. It captures period, half-period,
// dead-time and the clamped on-time on the first tick of every period,
// and pulses start_o on that tick.
// Assumes: en_i low holds the counter idle; the first period starts one
// clock after en_i goes high.
module bridge_timebase
    import bridge_pwm_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] ontime_i,
    input  logic [CNT_W-1:0] dead_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] half_o,
    output logic [CNT_W-1:0] dead_o,
    output logic [CNT_W-1:0] on_o,
    output logic             run_o,
    output logic             start_o
);

    localparam logic [CNT_W-1:0] PER_FLOOR = CNT_W'(MIN_PERIOD);

    logic [CNT_W-1:0] per_c, half_c, room_c, on_c;
    logic [CNT_W-1:0] per_q, half_q, dead_q, on_q, cnt_q;
    logic             run_q, start_q;
    logic             wrap;

    // Clamp the requested settings to the values a period will use.
    always_comb begin
        per_c  = (period_i < PER_FLOOR) ? PER_FLOOR : period_i;
        half_c = per_c >> 1;
        room_c = (dead_i >= half_c) ? '0 : (half_c - dead_i);
        on_c   = (ontime_i > room_c) ? room_c : ontime_i;
    end

    assign wrap = (cnt_q == per_q - 1'b1);

    // Tick counter and settings captured at each period start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            cnt_q   <= '0;
            start_q <= 1'b0;
            per_q   <= PER_FLOOR;
            half_q  <= PER_FLOOR >> 1;
            dead_q  <= '0;
            on_q    <= '0;
        end else if (!en_i) begin
            run_q   <= 1'b0;
            cnt_q   <= '0;
            start_q <= 1'b0;
        end else if (!run_q || wrap) begin
            run_q   <= 1'b1;
            cnt_q   <= '0;
            start_q <= 1'b1;
            per_q   <= per_c;
            half_q  <= half_c;
            dead_q  <= dead_i;
            on_q    <= on_c;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
            start_q <= 1'b0;
        end
    end

    assign cnt_o   = cnt_q;
    assign half_o  = half_q;
    assign dead_o  = dead_q;
    assign on_o    = on_q;
    assign run_o   = run_q;
    assign start_o = start_q;

endmodule

// File: rtl/bridge_window.sv
// Module: bridge_window
// Two-sided signed compare of the current sample against the limits.
// Assumes: lim_lo_i <= lim_hi_i. A sample equal to a limit counts as inside.
module bridge_window #(
    parameter int unsigned CUR_W = 12
) (
    input  logic signed [CUR_W-1:0] cur_i,
    input  logic signed [CUR_W-1:0] lim_hi_i,
    input  logic signed [CUR_W-1:0] lim_lo_i,
    output logic                    outside_o
);

    // Flag a sample above the upper limit or below the lower limit.
    always_comb begin
        outside_o = (cur_i > lim_hi_i) || (cur_i < lim_lo_i);
    end

endmodule

// File: rtl/bridge_limit.sv
// Module: bridge_limit
// Holds the current-limit state from a trip until the next period start.
// blank_o is high on the trip tick itself, and on every later tick until
// a period start finds the sample back inside the window.
// Assumes: start_i is high only on tick 0 of a period.
module bridge_limit (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic outside_i,
    input  logic start_i,
    output logic blank_o
);

    logic held_q;

    // Latch a trip; release it only at a period start with an in-window sample.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            held_q <= 1'b0;
        end else if (outside_i) begin
            held_q <= 1'b1;
        end else if (start_i) begin
            held_q <= 1'b0;
        end
    end

    // Blank now if the sample is outside, or if an earlier trip still holds.
    always_comb begin
        blank_o = outside_i || (held_q && !start_i);
    end

endmodule

// File: rtl/bridge_gate_gen.sv
// Module: bridge_gate_gen
// Decodes the tick count into the diagonal pair to drive and maps that
// pair onto the four gates. Blanking, disable and an idle timebase force
// every gate low.
// Assumes: dead_i + on_i <= half_i whenever on_i > 0 (the timebase clamps it).
module bridge_gate_gen
    import bridge_pwm_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             en_i,
    input  logic             run_i,
    input  logic             blank_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] half_i,
    input  logic [CNT_W-1:0] dead_i,
    input  logic [CNT_W-1:0] on_i,
    output logic             gate_ah_o,
    output logic             gate_al_o,
    output logic             gate_bh_o,
    output logic             gate_bl_o
);

    logic             first_half;
    logic [CNT_W-1:0] local_t;
    logic [CNT_W:0]   win_end;
    logic             in_win;
    pair_e            pair;

    // Position inside the current half and whether the on window covers it.
    always_comb begin
        first_half = (cnt_i < half_i);
        local_t    = first_half ? cnt_i : (cnt_i - half_i);
        win_end    = {1'b0, dead_i} + {1'b0, on_i};
        in_win     = (local_t >= dead_i) && ({1'b0, local_t} < win_end);
    end

    // Select the pair for this tick.
    always_comb begin
        if (!en_i || !run_i || blank_i || !in_win) begin
            pair = PAIR_NONE;
        end else if (first_half) begin
            pair = PAIR_POS;
        end else begin
            pair = PAIR_NEG;
        end
    end

    // Map the selected pair onto the four switches.
    always_comb begin
        gate_ah_o = 1'b0;
        gate_al_o = 1'b0;
        gate_bh_o = 1'b0;
        gate_bl_o = 1'b0;
        case (pair)
            PAIR_POS: begin
                gate_ah_o = 1'b1;
                gate_bl_o = 1'b1;
            end
            PAIR_NEG: begin
                gate_bh_o = 1'b1;
                gate_al_o = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/bridge_pwm_top.sv
// Module: bridge_pwm_top
// Full-bridge PWM with a windowed current limit that acts cycle by cycle.
// It ties together the timebase, the window compare, the limit hold and
// the gate decoder.
// Assumes: the current sample is already synchronous to clk.
module bridge_pwm_top #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned CUR_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en_i,
    input  logic [CNT_W-1:0]        period_i,
    input  logic [CNT_W-1:0]        ontime_i,
    input  logic [CNT_W-1:0]        dead_i,
    input  logic signed [CUR_W-1:0] lim_hi_i,
    input  logic signed [CUR_W-1:0] lim_lo_i,
    input  logic signed [CUR_W-1:0] cur_i,
    output logic                    gate_ah_o,
    output logic                    gate_al_o,
    output logic                    gate_bh_o,
    output logic                    gate_bl_o,
    output logic                    limit_o,
    output logic                    cyc_start_o
);

    logic [CNT_W-1:0] cnt, half, dead, on_eff;
    logic             run, start, outside, blank;

    bridge_timebase #(.CNT_W(CNT_W)) u_timebase (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en_i),
        .period_i (period_i),
        .ontime_i (ontime_i),
        .dead_i   (dead_i),
        .cnt_o    (cnt),
        .half_o   (half),
        .dead_o   (dead),
        .on_o     (on_eff),
        .run_o    (run),
        .start_o  (start)
    );

    bridge_window #(.CUR_W(CUR_W)) u_window (
        .cur_i     (cur_i),
        .lim_hi_i  (lim_hi_i),
        .lim_lo_i  (lim_lo_i),
        .outside_o (outside)
    );

    bridge_limit u_limit (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_i),
        .outside_i (outside),
        .start_i   (start),
        .blank_o   (blank)
    );

    bridge_gate_gen #(.CNT_W(CNT_W)) u_gates (
        .en_i      (en_i),
        .run_i     (run),
        .blank_i   (blank),
        .cnt_i     (cnt),
        .half_i    (half),
        .dead_i    (dead),
        .on_i      (on_eff),
        .gate_ah_o (gate_ah_o),
        .gate_al_o (gate_al_o),
        .gate_bh_o (gate_bh_o),
        .gate_bl_o (gate_bl_o)
    );

    // The flag reports blanking only while the block is enabled.
    always_comb begin
        limit_o = en_i && blank;
    end

    assign cyc_start_o = start;

endmodule

// File: rtl/bridge_pwm_chk.sv
// Module: bridge_pwm_chk
// Port-level properties of bridge_pwm_top. It is bound to the top below.
// Assumes: clk and the synchronous active-low rst_n of the top.
module bridge_pwm_chk #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned CUR_W = 12
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    en_i,
    input logic [CNT_W-1:0]        period_i,
    input logic [CNT_W-1:0]        ontime_i,
    input logic [CNT_W-1:0]        dead_i,
    input logic signed [CUR_W-1:0] lim_hi_i,
    input logic signed [CUR_W-1:0] lim_lo_i,
    input logic signed [CUR_W-1:0] cur_i,
    input logic                    gate_ah_o,
    input logic                    gate_al_o,
    input logic                    gate_bh_o,
    input logic                    gate_bl_o,
    input logic                    limit_o,
    input logic                    cyc_start_o
);

    logic any_gate;
    assign any_gate = gate_ah_o | gate_al_o | gate_bh_o | gate_bl_o;

    AST_LEG_A_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_ah_o && gate_al_o));  // R7
    AST_LEG_B_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_bh_o && gate_bl_o));  // R7
    AST_OUTSIDE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && ((cur_i > lim_hi_i) || (cur_i < lim_lo_i))) |-> limit_o);  // R1
    AST_BLANK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        limit_o |-> !any_gate);  // R5
    AST_LIMIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && limit_o) |=> (limit_o || cyc_start_o || !en_i));  // R5
    AST_RELEASE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(limit_o) && en_i && $past(en_i)) |-> cyc_start_o);  // R6
    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start_o |=> !cyc_start_o);  // R9
    AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> (!any_gate && !limit_o));  // R10

endmodule

bind bridge_pwm_top bridge_pwm_chk #(.CNT_W(CNT_W), .CUR_W(CUR_W)) u_chk (.*);

// File: tb/bridge_pwm_top_bench.sv
// Bench for bridge_pwm_top. A behavioural model kept in integers is
// compared with the ports on every falling edge. Directed checks add to it.
module bridge_pwm_top_bench;

    localparam int CNT_W = 16;
    localparam int CUR_W = 12;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    en_i = 1'b0;
    logic [CNT_W-1:0]        period_i = 16'd40;
    logic [CNT_W-1:0]        ontime_i = 16'd18;
    logic [CNT_W-1:0]        dead_i = 16'd2;
    logic signed [CUR_W-1:0] lim_hi_i = 12'sd1000;
    logic signed [CUR_W-1:0] lim_lo_i = -12'sd1000;
    logic signed [CUR_W-1:0] cur_i = 12'sd0;
    logic gate_ah_o, gate_al_o, gate_bh_o, gate_bl_o, limit_o, cyc_start_o;

    bridge_pwm_top #(.CNT_W(CNT_W), .CUR_W(CUR_W)) u_bridge_pwm_top (.*);

    always #4 clk = ~clk;

    int n_checks = 0;
    int n_fail = 0;
    bit mon_on = 1'b0;
    bit finished = 1'b0;

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural model state.
    int m_run, m_cnt, m_per, m_half, m_dead, m_on, m_lim, m_start;

    function automatic int is_out();
        return (int'(cur_i) > int'(lim_hi_i)) || (int'(cur_i) < int'(lim_lo_i));
    endfunction

    always @(posedge clk) begin
        int o, p, h, r;
        if (!rst_n) begin
            m_run = 0; m_cnt = 0; m_lim = 0; m_start = 0;
            m_per = 4; m_half = 2; m_dead = 0; m_on = 0;
        end else begin
            o = is_out();
            if (!en_i) m_lim = 0;
            else if (o != 0) m_lim = 1;
            else if (m_start != 0) m_lim = 0;
            if (!en_i) begin
                m_run = 0; m_cnt = 0; m_start = 0;
            end else if (m_run == 0 || m_cnt == m_per - 1) begin
                p = (int'(period_i) < 4) ? 4 : int'(period_i);
                h = p / 2;
                r = (int'(dead_i) >= h) ? 0 : h - int'(dead_i);
                m_per = p; m_half = h; m_dead = int'(dead_i);
                m_on = (int'(ontime_i) > r) ? r : int'(ontime_i);
                m_run = 1; m_cnt = 0; m_start = 1;
            end else begin
                m_cnt++; m_start = 0;
            end
        end
    end

    // Compare the ports with the model on every falling edge.
    always @(negedge clk) begin
        int blank, act, first, loc, win, ea, eb, got, want;
        if (mon_on && rst_n && !finished) begin
            blank = (is_out() != 0) || (m_lim != 0 && m_start == 0);
            act   = en_i && (m_run != 0);
            first = m_cnt < m_half;
            loc   = first ? m_cnt : m_cnt - m_half;
            win   = (loc >= m_dead) && (loc < m_dead + m_on);
            ea    = act && win && !blank && first;
            eb    = act && win && !blank && !first;
            got   = {gate_ah_o, gate_bl_o, gate_bh_o, gate_al_o};
            want  = {ea[0], ea[0], eb[0], eb[0]};
            check("R2/R3 gate pattern", got, want);
            check("R1/R5 limit flag", int'(limit_o), int'(en_i && blank));
            check("R9 start strobe", int'(cyc_start_o), m_start);
            check("R7 leg exclusive",
                  int'((gate_ah_o && gate_al_o) || (gate_bh_o && gate_bl_o)), 0);
        end
    end

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_start();
        @(negedge clk);
        while (!cyc_start_o) @(negedge clk);
    endtask

    // Count ticks of one full period that begins at the next start.
    task automatic measure(output int ah, output int bh, output int len);
        wait_start();
        ah = 0; bh = 0; len = 0;
        do begin
            ah += int'(gate_ah_o);
            bh += int'(gate_bh_o);
            len++;
            @(negedge clk);
        end while (!cyc_start_o);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int ah, bh, len, guard;
        ticks(3);
        // R10: reset state
        check("R10 reset gates",
              int'({gate_ah_o, gate_al_o, gate_bh_o, gate_bl_o}), 0);
        check("R10 reset limit", int'(limit_o), 0);
        check("R9 reset start", int'(cyc_start_o), 0);
        #1 rst_n = 1'b1;
        mon_on = 1'b1;
        ticks(2);
        #1 en_i = 1'b1;

        // R3: nominal on-time per half
        measure(ah, bh, len);
        check("R3 ah ticks", ah, 18);
        check("R3 bh ticks", bh, 18);
        check("R2 period length", len, 40);

        // R4: clamp to half minus dead
        #1 ontime_i = 16'd30; dead_i = 16'd4;
        measure(ah, bh, len);
        check("R4 clamped ah", ah, 16);
        check("R4 clamped bh", bh, 16);

        // R4: dead-time of half or more wipes out the pulse
        #1 dead_i = 16'd25; ontime_i = 16'd10;
        measure(ah, bh, len);
        check("R4 dead>=half ah", ah, 0);

        // R4: tiny period floored
        #1 period_i = 16'd2; dead_i = 16'd0; ontime_i = 16'd2;
        measure(ah, bh, len);
        check("R4 period floor", len, 4);
        check("R4 floor ah", ah, 2);

        // R2: odd period, no dead-time
        #1 period_i = 16'd41; ontime_i = 16'd20; dead_i = 16'd0;
        measure(ah, bh, len);
        check("R2 odd length", len, 41);
        check("R2 odd ah", ah, 20);
        check("R2 odd bh", bh, 20);

        // R8: mid-period change does not alter the running period
        #1 period_i = 16'd40; ontime_i = 16'd18; dead_i = 16'd2;
        wait_start();
        ticks(3);
        #1 period_i = 16'd24;
        len = 3;
        while (!cyc_start_o) begin @(negedge clk); len++; end
        check("R8 old length kept", len, 40);
        measure(ah, bh, len);
        check("R8 new length", len, 24);
        #1 period_i = 16'd40;
        wait_start();

        // R1: sample equal to a limit is inside
        #1 cur_i = 12'sd1000;
        ticks(1);
        check("R1 equal hi inside", int'(limit_o), 0);
        #1 cur_i = -12'sd1000;
        ticks(1);
        check("R1 equal lo inside", int'(limit_o), 0);
        #1 cur_i = 12'sd0;

        // R5: single-tick trip in the middle of the first pair
        wait_start();
        ticks(5);
        check("R5 pair on before trip", int'(gate_ah_o), 1);
        #1 cur_i = 12'sd1001;
        ticks(1);
        check("R5 trip blanks now", int'(gate_ah_o), 0);
        check("R1 trip flag", int'(limit_o), 1);
        #1 cur_i = 12'sd0;
        ticks(4);
        check("R5 held after return", int'(limit_o), 1);
        check("R5 gates held off", int'(gate_ah_o), 0);
        // R6: release at next period start
        wait_start();
        check("R6 release at start", int'(limit_o), 0);
        ticks(3);
        check("R6 switching resumes", int'(gate_ah_o), 1);

        // R6: sample outside across a period start blanks the whole period
        #1 cur_i = -12'sd1001;
        measure(ah, bh, len);
        check("R6 blanked ah", ah, 0);
        check("R6 blanked bh", bh, 0);
        #1 cur_i = 12'sd0;
        measure(ah, bh, len);
        check("R6 recovered ah", ah, 18);

        // R10: enable drop mid-period, restart with first pair
        wait_start();
        ticks(25);
        #1 en_i = 1'b0;
        ticks(1);
        check("R10 disable gates",
              int'({gate_ah_o, gate_al_o, gate_bh_o, gate_bl_o}), 0);
        check("R10 disable limit", int'(limit_o), 0);
        ticks(3);
        #1 en_i = 1'b1;
        ticks(1);
        check("R9 start after enable", int'(cyc_start_o), 1);
        guard = 0;
        while (!(gate_ah_o || gate_bh_o) && guard < 100) begin
            @(negedge clk); guard++;
        end
        check("R10 first pair is A-high", int'(gate_ah_o), 1);

        ticks(50);
        finish_run();
    end

endmodule